// File: doc/BRIEF.md
# Boundary Scan Cell Chain with Pad and Core Test Multiplexers

This block is the boundary register for a group of general-purpose I/O pads. Each pad contributes three cells: one for the value the core drives out, one for the output enable, and one for the value arriving from the pad. A single extra cell watches the external reset pin. The TAP controller supplies the capture, shift and update strobes, and a select flag that says boundary scan is the data register in use. Live values are captured into the chain, shifted out one bit per clock toward the serial output while fresh bits enter from the serial input, and then copied into a parallel hold stage.

Two mode flags from the instruction decoder steer the multiplexers. The pad-drive mode replaces the core's output and enable values with the held ones. The core-drive mode replaces the values the core reads from the pads with the held ones. Both modes use whatever the last sample-and-preload pass left in the hold stage, so no separate load step is needed. The reset cell can be read but never drives anything. While the TAP sits in its reset state, both modes are masked at once, so the pads and the core go back to their functional values in the same clock.

Top module: `bscan_chain_top`

## Requirements
- R1: While `sel_bsr` and `capture_dr` are high, a clock edge loads the chain in parallel. Chain position 3p takes `core_out[p]`, 3p+1 takes `core_oe[p]`, 3p+2 takes `pad_in[p]`, and position 3N takes `rst_pin_n`. Capture has priority over shift.
- R2: While `sel_bsr` and `shift_dr` are high and `capture_dr` is low, each edge moves the chain one place toward position 0. Position 3N takes `tdi`. `tdo` always shows position 0, so the bits leave in the order pad 0 output, pad 0 enable, pad 0 input, pad 1 output, and so on, with the reset cell last.
- R3: While `sel_bsr` is low, the capture, shift and update strobes have no effect on the chain or the hold stage.
- R4: A clock edge with `sel_bsr` and `update_dr` high copies the whole chain into the hold stage. At all other times the hold stage keeps its contents, including when the mode flags change.
- R5: With no mode active, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in`. This also holds while a capture, shift or update pass is in progress.
- R6: When `mode_extest` is active, `pad_out[p]` and `pad_oe[p]` come from hold positions 3p and 3p+1. `core_in` still follows `pad_in`.
- R7: When `mode_intest` is active, `core_in[p]` comes from hold position 3p+2. The pads keep their functional values unless `mode_extest` is also active.
- R8: `core_rst_n` always equals `rst_pin_n`, in every mode and whatever the reset cell holds.
- R9: While `tlr` is high, both modes are masked in the same cycle and every output takes its functional value. The hold stage keeps its contents, so the test values return when `tlr` falls.
- R10: A low level on `trst_n` clears the chain and the hold stage to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | TAP is in its reset state; masks both modes |
| sel_bsr | input | 1 | Boundary register is the selected data register |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| mode_extest | input | 1 | Pad-drive mode from the instruction decoder |
| mode_intest | input | 1 | Core-drive mode from the instruction decoder |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain position 0) |
| core_out | input | NUM_PADS | Output values from the core |
| core_oe | input | NUM_PADS | Output enables from the core |
| pad_in | input | NUM_PADS | Values arriving from the pads |
| rst_pin_n | input | 1 | External reset pin level |
| pad_out | output | NUM_PADS | Output values to the pads |
| pad_oe | output | NUM_PADS | Output enables to the pads |
| core_in | output | NUM_PADS | Input values to the core |
| core_rst_n | output | 1 | Reset to the core |

## Verification
On every clock, the assertions check the single shift step, the reset cell capture, the hold stage loading only on a selected update and otherwise staying still, the masking by `tlr`, the reset pass-through, and for each pad that an active mode routes the matching hold bit. Only the bench's scenarios can show the full serial order of a captured frame, a complete preload followed by pad-drive and core-drive use, the test values coming back after `tlr` falls, and the effect of the asynchronous reset between clock edges.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // Chain position helpers; position 0 sits at the serial output.
  function automatic int unsigned out_pos(int unsigned p);
    return 3 * p;
  endfunction
  function automatic int unsigned oe_pos(int unsigned p);
    return 3 * p + 1;
  endfunction
  function automatic int unsigned in_pos(int unsigned p);
    return 3 * p + 2;
  endfunction
  function automatic int unsigned rst_pos(int unsigned n_pads);
    return 3 * n_pads;
  endfunction
  function automatic int unsigned chain_len(int unsigned n_pads);
    return 3 * n_pads + 1;
  endfunction
endpackage

// File: rtl/bscan_shift.sv
module bscan_shift #(
  parameter int unsigned NUM_PADS = 4,
  localparam int unsigned LEN = bscan_pkg::chain_len(NUM_PADS)
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                cap_en,
  input  logic                shf_en,
  input  logic                tdi,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                rst_pin_n,
  output logic [LEN-1:0]      chain_q
);
  logic [LEN-1:0] snap;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_snap
    assign snap[bscan_pkg::out_pos(p)] = core_out[p];
    assign snap[bscan_pkg::oe_pos(p)]  = core_oe[p];
    assign snap[bscan_pkg::in_pos(p)]  = pad_in[p];
  end
  assign snap[bscan_pkg::rst_pos(NUM_PADS)] = rst_pin_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     chain_q <= '0;
    else if (cap_en) chain_q <= snap;
    else if (shf_en) chain_q <= {tdi, chain_q[LEN-1:1]};
  end
endmodule

// File: rtl/bscan_hold.sv
module bscan_hold #(
  parameter int unsigned LEN = 13
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           upd_en,
  input  logic [LEN-1:0] chain_d,
  output logic [LEN-1:0] hold_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hold_q <= '0;
    else if (upd_en) hold_q <= chain_d;
  end
endmodule

// File: rtl/bscan_mux.sv
module bscan_mux #(
  parameter int unsigned NUM_PADS = 4,
  localparam int unsigned LEN = bscan_pkg::chain_len(NUM_PADS)
) (
  input  logic                ext_act,
  input  logic                int_act,
  input  logic [LEN-1:0]      hold_q,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] core_in
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int unsigned OP = bscan_pkg::out_pos(p);
    localparam int unsigned EP = bscan_pkg::oe_pos(p);
    localparam int unsigned IP = bscan_pkg::in_pos(p);
    assign pad_out[p] = ext_act ? hold_q[OP] : core_out[p];
    assign pad_oe[p]  = ext_act ? hold_q[EP] : core_oe[p];
    assign core_in[p] = int_act ? hold_q[IP] : pad_in[p];
  end
endmodule

// File: rtl/bscan_chain_top.sv
module bscan_chain_top #(
  parameter int unsigned NUM_PADS = 4,
  localparam int unsigned LEN = bscan_pkg::chain_len(NUM_PADS)
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tlr,
  input  logic                sel_bsr,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  input  logic                mode_extest,
  input  logic                mode_intest,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                rst_pin_n,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] core_in,
  output logic                core_rst_n
);
  logic           cap_en, shf_en, upd_en;
  logic           ext_act, int_act;
  logic [LEN-1:0] chain_q, hold_q;

  // Named strobes, visible to the checker.
  assign cap_en  = sel_bsr & capture_dr;
  assign shf_en  = sel_bsr & shift_dr & ~capture_dr;
  assign upd_en  = sel_bsr & update_dr;
  assign ext_act = mode_extest & ~tlr;
  assign int_act = mode_intest & ~tlr;

  bscan_shift #(.NUM_PADS(NUM_PADS)) u_shift (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shf_en(shf_en), .tdi(tdi),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .rst_pin_n(rst_pin_n), .chain_q(chain_q)
  );

  bscan_hold #(.LEN(LEN)) u_hold (
    .tck(tck), .trst_n(trst_n), .upd_en(upd_en), .chain_d(chain_q),
    .hold_q(hold_q)
  );

  bscan_mux #(.NUM_PADS(NUM_PADS)) u_mux (
    .ext_act(ext_act), .int_act(int_act), .hold_q(hold_q),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
  );

  assign tdo        = chain_q[0];
  assign core_rst_n = rst_pin_n;  // reset cell observes only
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int unsigned NUM_PADS = 4,
  localparam int unsigned LEN = bscan_pkg::chain_len(NUM_PADS)
) (
  input logic                tck,
  input logic                trst_n,
  input logic                tlr,
  input logic                sel_bsr,
  input logic                capture_dr,
  input logic                shift_dr,
  input logic                update_dr,
  input logic                mode_extest,
  input logic                mode_intest,
  input logic                tdi,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic [NUM_PADS-1:0] pad_in,
  input logic                rst_pin_n,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] core_in,
  input logic                core_rst_n,
  input logic [LEN-1:0]      chain_q,
  input logic [LEN-1:0]      hold_q
);
  localparam int unsigned RP = bscan_pkg::rst_pos(NUM_PADS);

  assert_rst_cell_capture_R1: assert property (@(posedge tck) disable iff (!trst_n)
    sel_bsr && capture_dr |=> chain_q[RP] == $past(rst_pin_n));

  assert_shift_step_R2: assert property (@(posedge tck) disable iff (!trst_n)
    sel_bsr && shift_dr && !capture_dr |=>
      chain_q == {$past(tdi), $past(chain_q[LEN-1:1])});

  assert_unselected_quiet_R3: assert property (@(posedge tck) disable iff (!trst_n)
    !sel_bsr |=> $stable(chain_q) && $stable(hold_q));

  assert_update_load_R4: assert property (@(posedge tck) disable iff (!trst_n)
    sel_bsr && update_dr |=> hold_q == $past(chain_q));

  assert_hold_keep_R4: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel_bsr && update_dr) |=> $stable(hold_q));

  assert_functional_pads_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !mode_extest |-> pad_out == core_out && pad_oe == core_oe);

  assert_functional_core_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !mode_intest |-> core_in == pad_in);

  assert_reset_passthru_R8: assert property (@(posedge tck) disable iff (!trst_n)
    core_rst_n == rst_pin_n);

  assert_tlr_mask_R9: assert property (@(posedge tck) disable iff (!trst_n)
    tlr |-> pad_out == core_out && pad_oe == core_oe && core_in == pad_in);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
    assert_pad_drive_R6: assert property (@(posedge tck) disable iff (!trst_n)
      mode_extest && !tlr |-> pad_out[p] == hold_q[3*p] && pad_oe[p] == hold_q[3*p+1]);
    assert_core_drive_R7: assert property (@(posedge tck) disable iff (!trst_n)
      mode_intest && !tlr |-> core_in[p] == hold_q[3*p+2]);
  end
endmodule

bind bscan_chain_top bscan_chain_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .tck(tck), .trst_n(trst_n), .tlr(tlr), .sel_bsr(sel_bsr),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .mode_extest(mode_extest), .mode_intest(mode_intest), .tdi(tdi),
  .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
  .rst_pin_n(rst_pin_n), .pad_out(pad_out), .pad_oe(pad_oe),
  .core_in(core_in), .core_rst_n(core_rst_n), .chain_q(chain_q),
  .hold_q(hold_q)
);

// File: tb/bscan_chain_top_tb.sv
module bscan_chain_top_tb;
  localparam int N = 4;
  localparam int L = 3 * N + 1;

  logic tck = 0, trst_n = 0, tlr = 0, sel_bsr = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic mode_extest = 0, mode_intest = 0, tdi = 0, rst_pin_n = 1;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic tdo, core_rst_n;
  logic [N-1:0] pad_out, pad_oe, core_in;

  int checks = 0, errors = 0;
  bit done = 0;

  bit chain_m[$];
  bit hold_m[L];

  always #5 tck = ~tck;

  bscan_chain_top #(.NUM_PADS(N)) u_dut (
    .tck(tck), .trst_n(trst_n), .tlr(tlr), .sel_bsr(sel_bsr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .mode_extest(mode_extest), .mode_intest(mode_intest), .tdi(tdi),
    .tdo(tdo), .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .rst_pin_n(rst_pin_n), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_in(core_in), .core_rst_n(core_rst_n)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    chain_m.delete();
    repeat (L) chain_m.push_back(1'b0);
    foreach (hold_m[i]) hold_m[i] = 1'b0;
  endtask

  task automatic model_edge();
    if (sel_bsr && update_dr)
      foreach (hold_m[i]) hold_m[i] = chain_m[i];
    if (sel_bsr && capture_dr) begin
      chain_m.delete();
      for (int p = 0; p < N; p++) begin
        chain_m.push_back(core_out[p]);
        chain_m.push_back(core_oe[p]);
        chain_m.push_back(pad_in[p]);
      end
      chain_m.push_back(rst_pin_n);
    end else if (sel_bsr && shift_dr) begin
      void'(chain_m.pop_front());
      chain_m.push_back(tdi);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] eo, ee, ei;
    bit ext, inn;
    ext = mode_extest && !tlr;
    inn = mode_intest && !tlr;
    for (int p = 0; p < N; p++) begin
      eo[p] = ext ? hold_m[3*p]   : core_out[p];
      ee[p] = ext ? hold_m[3*p+1] : core_oe[p];
      ei[p] = inn ? hold_m[3*p+2] : pad_in[p];
    end
    chk(pad_out == eo, ext ? "R6 pad_out" : "R5 pad_out", pad_out, eo);
    chk(pad_oe == ee,  ext ? "R6 pad_oe" : "R5 pad_oe", pad_oe, ee);
    chk(core_in == ei, inn ? "R7 core_in" : "R5 core_in", core_in, ei);
    chk(tdo == chain_m[0], "R2 tdo", tdo, chain_m[0]);
    chk(core_rst_n == rst_pin_n, "R8 core_rst_n", core_rst_n, rst_pin_n);
  endtask

  task automatic tick();
    @(posedge tck);
    if (trst_n) model_edge();
    @(negedge tck);
    compare_all();
  endtask

  function automatic logic [L-1:0] frame(logic [N-1:0] o, logic [N-1:0] e,
                                         logic [N-1:0] i, logic r);
    logic [L-1:0] f;
    for (int p = 0; p < N; p++) begin
      f[3*p] = o[p]; f[3*p+1] = e[p]; f[3*p+2] = i[p];
    end
    f[L-1] = r;
    return f;
  endfunction

  // Capture, then shift out L bits while loading pat, then update.
  task automatic scan_pass(logic [L-1:0] pat, logic [L-1:0] expect_out);
    sel_bsr = 1; capture_dr = 1;
    tick();
    capture_dr = 0; shift_dr = 1;
    for (int b = 0; b < L; b++) begin
      chk(tdo == expect_out[b], "R2 shift order", tdo, expect_out[b]);
      tdi = pat[b];
      tick();
    end
    shift_dr = 0; update_dr = 1;
    tick();
    update_dr = 0; sel_bsr = 0;
    tick();
  endtask

  initial begin
    logic [L-1:0] pat_a, pat_b;
    model_reset();
    repeat (3) @(negedge tck);
    compare_all();
    chk(tdo == 1'b0, "R10 reset tdo", tdo, 0);
    trst_n = 1;
    tick();

    // Sample/preload with live functional traffic.
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011; rst_pin_n = 1;
    pat_a = frame(4'b0101, 4'b1111, 4'b1001, 1'b0);
    scan_pass(pat_a, frame(4'b1010, 4'b0110, 4'b0011, 1'b1));
    chk(pad_out == 4'b1010, "R5 pads during preload", pad_out, 4'b1010);
    chk(core_in == 4'b0011, "R5 core during preload", core_in, 4'b0011);

    // Pad-drive mode.
    mode_extest = 1;
    tick();
    chk(pad_out == 4'b0101, "R6 pad_out", pad_out, 4'b0101);
    chk(pad_oe == 4'b1111, "R6 pad_oe", pad_oe, 4'b1111);
    chk(core_in == 4'b0011, "R6 core_in functional", core_in, 4'b0011);
    core_out = 4'b0000;
    tick();
    chk(pad_out == 4'b0101, "R6 core change ignored", pad_out, 4'b0101);

    // Unselected strobes must not touch chain or hold.
    sel_bsr = 0; capture_dr = 1; tick();
    capture_dr = 0; shift_dr = 1; tdi = 1; tick(); tick();
    shift_dr = 0; update_dr = 1; tick();
    update_dr = 0;
    chk(pad_out == 4'b0101, "R3 hold unchanged", pad_out, 4'b0101);
    chk(tdo == pat_a[0], "R3 chain unchanged", tdo, pat_a[0]);

    // Mode changes keep the hold stage.
    mode_extest = 0; mode_intest = 1;
    tick();
    chk(core_in == 4'b1001, "R7 core_in", core_in, 4'b1001);
    chk(pad_out == core_out, "R7 pads functional", pad_out, core_out);
    chk(core_rst_n == 1'b1, "R8 reset cell holds 0", core_rst_n, 1);
    rst_pin_n = 0; tick();
    chk(core_rst_n == 1'b0, "R8 follows pin", core_rst_n, 0);
    rst_pin_n = 1;
    mode_extest = 1;
    tick();
    chk(pad_out == 4'b0101, "R4 hold kept over modes", pad_out, 4'b0101);

    // Second preload, both modes on.
    core_out = 4'b1100; core_oe = 4'b1001; pad_in = 4'b0110;
    pat_b = frame(4'b1011, 4'b0010, 4'b0110, 1'b1);
    scan_pass(pat_b, frame(4'b1100, 4'b1001, 4'b0110, 1'b1));
    chk(pad_out == 4'b1011, "R4 new hold on pads", pad_out, 4'b1011);
    chk(core_in == 4'b0110, "R4 new hold on core", core_in, 4'b0110);

    // Test-logic-reset masks modes in the same cycle.
    pad_in = 4'b1111;
    tlr = 1; #1;
    compare_all();
    chk(pad_out == core_out, "R9 pad_out", pad_out, core_out);
    chk(core_in == pad_in, "R9 core_in", core_in, pad_in);
    tick();
    tlr = 0; #1;
    chk(pad_out == 4'b1011, "R9 hold returns", pad_out, 4'b1011);
    chk(pad_oe == 4'b0010, "R9 hold returns oe", pad_oe, 4'b0010);
    tick();

    // Asynchronous test reset between edges.
    #2 trst_n = 0; #1;
    model_reset();
    compare_all();
    chk(tdo == 1'b0, "R10 tdo", tdo, 0);
    chk(pad_out == 4'b0000, "R10 hold cleared", pad_out, 4'b0000);
    @(negedge tck);
    trst_n = 1;
    tick();
    mode_extest = 0; mode_intest = 0;
    tick();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule